// File: doc/BRIEF.md
# Integration Window Acquisition Controller

This controller is the shared timing block for a bank of pulse-counting channels. It cuts time into integration windows whose width is a programmable number of clock cycles. It marks the last cycle of each window with a single-cycle strobe, so that every channel latches its count in the same cycle. It also tells the channels how many consecutive results go into each 32-bit word: one 32-bit result, two 16-bit results, or four 8-bit results. It raises a one-cycle interrupt each time the channels hold a complete word.

A host processor sets the block up over a simple register bus. Acquisition runs in one of two modes:
- **Continuous:** windows run back to back with no idle cycle between them, until the host asks for a stop.
- **Triggered:** the controller waits for a rising edge on an asynchronous trigger pin, waits a programmable number of cycles, then runs for a programmable number of windows.

A status register reports which phase the sequencer is in.

Top module: `acq_window_ctrl`

## Requirements
- R1: While reset is held and right after it, the sequencer is in the idle phase. Status reads 0, and both `win_end` and `pkt_irq` are low.
- R2: The registers are word addressed:
  - Address 0, control (write only): bit 0 starts, bit 1 stops. It reads 0.
  - Address 1, configuration: bits [1:0] format, bit 2 triggered mode.
  - Address 2: window width (24 bits).
  - Address 3: post-trigger delay in cycles (24 bits).
  - Address 4: acquisition length in windows (16 bits).
  - Address 5, status (read only): bits [1:0] = 0 idle, 1 armed, 2 delay, 3 acquire.
  - Written values read back.
- R3: In continuous mode, a start written at clock edge E begins acquisition at once. `win_end` is high in the W-th cycle after E and then every W cycles, with no gap, where W is the width register.
- R4: A width of 0 gives one-cycle windows, so `win_end` is high in every acquisition cycle.
- R5: The format is latched at start and driven on `fmt_sel` for the whole run. Format 0 and 3 pack 1 result per word, format 1 packs 2, and format 2 packs 4. `pkt_irq` is high for one cycle right after the window end that completes a word.
- R6: A stop written during acquisition takes effect at the next window end, after which the block is idle. A stop in the armed or delay phase returns to idle at once.
- R7: A start in triggered mode enters the armed phase. A trigger rising edge, after two synchronizer stages, moves to the delay phase. Acquisition begins exactly D cycles later, or directly from armed when D is 0.
- R8: In triggered mode, acquisition ends after the programmed number of windows, and a length of 0 runs until stopped. The final window always raises `pkt_irq`, flushing a partly filled word.
- R9: The trigger has no effect unless the sequencer is in the armed phase.
- R10: `pkt_irq` is only ever high in the cycle after a `win_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| trig_in | input | 1 | Asynchronous trigger |
| win_end | output | 1 | Last cycle of a window |
| fmt_sel | output | 2 | Packing format to the channels |
| pkt_irq | output | 1 | Packed word ready |

## Verification
The checker watches several rules on every cycle:
- An interrupt is never raised without a window end in the previous cycle.
- The window strobe only appears while acquiring.
- The format output stays stable through a run.
- The delay phase is entered only from the armed phase.
- Leaving the armed phase toward acquisition is always caused by a synchronized trigger edge.
- Acquisition only ends on a window boundary.

The exact window period, the interrupt spacing for each packing factor, the trigger delay count, the length limit with its flush, and the ignored triggers all depend on programmed values. Only the bench's directed scenarios can show those.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_ACQ   = 2'd3
  } acq_state_e;

  typedef struct packed {
    logic       trig_mode;
    logic [1:0] fmt;
  } acq_cfg_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CFG    = 3'd1;
  localparam logic [2:0] A_WIDTH  = 3'd2;
  localparam logic [2:0] A_DELAY  = 3'd3;
  localparam logic [2:0] A_LEN    = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;

  // results per word minus one
  function automatic logic [1:0] pack_m1(input logic [1:0] fmt);
    case (fmt)
      2'd1:    pack_m1 = 2'd1;
      2'd2:    pack_m1 = 2'd3;
      default: pack_m1 = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
endmodule

// File: rtl/acq_regs.sv
module acq_regs
  import acq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_W  = 24,
  parameter int DLY_W  = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  acq_state_e        state_i,
  output logic              start_o,
  output logic              stop_o,
  output acq_cfg_t          cfg_o,
  output logic [WIN_W-1:0]  width_o,
  output logic [DLY_W-1:0]  delay_o,
  output logic [LEN_W-1:0]  len_o
);
  logic     wr_en;
  logic     cfg_en, width_en, delay_en, len_en;
  acq_cfg_t cfg_q;
  logic [WIN_W-1:0] width_q;
  logic [DLY_W-1:0] delay_q;
  logic [LEN_W-1:0] len_q;

  assign wr_en    = bus_sel & bus_wr;
  assign cfg_en   = wr_en & (bus_addr == A_CFG);
  assign width_en = wr_en & (bus_addr == A_WIDTH);
  assign delay_en = wr_en & (bus_addr == A_DELAY);
  assign len_en   = wr_en & (bus_addr == A_LEN);
  assign start_o  = wr_en & (bus_addr == A_CTRL) & bus_wdata[0];
  assign stop_o   = wr_en & (bus_addr == A_CTRL) & bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      width_q <= '0;
      delay_q <= '0;
      len_q   <= '0;
    end else begin
      if (cfg_en)   cfg_q   <= acq_cfg_t'(bus_wdata[2:0]);
      if (width_en) width_q <= bus_wdata[WIN_W-1:0];
      if (delay_en) delay_q <= bus_wdata[DLY_W-1:0];
      if (len_en)   len_q   <= bus_wdata[LEN_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CFG:    bus_rdata[2:0]       = cfg_q;
        A_WIDTH:  bus_rdata[WIN_W-1:0] = width_q;
        A_DELAY:  bus_rdata[DLY_W-1:0] = delay_q;
        A_LEN:    bus_rdata[LEN_W-1:0] = len_q;
        A_STATUS: bus_rdata[1:0]       = state_i;
        default:  bus_rdata            = '0;
      endcase
    end
  end

  assign cfg_o   = cfg_q;
  assign width_o = width_q;
  assign delay_o = delay_q;
  assign len_o   = len_q;
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int DLY_W = 24,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             trig_rise_i,
  input  acq_cfg_t         cfg_i,
  input  logic [WIN_W-1:0] width_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [LEN_W-1:0] len_i,
  output acq_state_e       state_o,
  output logic             win_end_o,
  output logic [1:0]       fmt_o,
  output logic             pkt_irq_o
);
  localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};
  localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  acq_state_e       state_q, state_d;
  logic [WIN_W-1:0] wcnt_q, wcnt_d, width_m1;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic [LEN_W-1:0] lcnt_q, lcnt_d;
  logic [1:0]       slot_q, slot_d, fmt_q, fmt_d;
  logic             mode_q, mode_d;
  logic             spend_q, spend_d;
  logic             irq_q, irq_d;
  logic             win_end, len_hit, finish, pkt_done, dly_hit;

  assign width_m1 = (width_i == '0) ? '0 : (width_i - WIN_ONE);
  assign win_end  = (state_q == ST_ACQ) && (wcnt_q >= width_m1);
  assign len_hit  = mode_q && (len_i != '0) && (lcnt_q == (len_i - LEN_ONE));
  assign finish   = win_end && (spend_q || stop_i || len_hit);
  assign pkt_done = win_end && ((slot_q == pack_m1(fmt_q)) || finish);
  assign dly_hit  = (dcnt_q + DLY_ONE) >= delay_i;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    dcnt_d  = dcnt_q;
    lcnt_d  = lcnt_q;
    slot_d  = slot_q;
    fmt_d   = fmt_q;
    mode_d  = mode_q;
    spend_d = spend_q;
    irq_d   = pkt_done;
    case (state_q)
      ST_IDLE: begin
        wcnt_d  = '0;
        dcnt_d  = '0;
        lcnt_d  = '0;
        slot_d  = '0;
        spend_d = 1'b0;
        if (start_i) begin
          fmt_d   = cfg_i.fmt;
          mode_d  = cfg_i.trig_mode;
          state_d = cfg_i.trig_mode ? ST_ARMED : ST_ACQ;
        end
      end
      ST_ARMED: begin
        dcnt_d = '0;
        if (stop_i)           state_d = ST_IDLE;
        else if (trig_rise_i) state_d = (delay_i == '0) ? ST_ACQ : ST_DELAY;
      end
      ST_DELAY: begin
        dcnt_d = dcnt_q + DLY_ONE;
        if (stop_i)       state_d = ST_IDLE;
        else if (dly_hit) state_d = ST_ACQ;
      end
      ST_ACQ: begin
        if (stop_i) spend_d = 1'b1;
        if (win_end) begin
          wcnt_d = '0;
          lcnt_d = lcnt_q + LEN_ONE;
          slot_d = pkt_done ? 2'd0 : (slot_q + 2'd1);
          if (finish) state_d = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q + WIN_ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      dcnt_q  <= '0;
      lcnt_q  <= '0;
      slot_q  <= '0;
      fmt_q   <= '0;
      mode_q  <= 1'b0;
      spend_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      dcnt_q  <= dcnt_d;
      lcnt_q  <= lcnt_d;
      slot_q  <= slot_d;
      fmt_q   <= fmt_d;
      mode_q  <= mode_d;
      spend_q <= spend_d;
      irq_q   <= irq_d;
    end
  end

  assign state_o   = state_q;
  assign win_end_o = win_end;
  assign fmt_o     = fmt_q;
  assign pkt_irq_o = irq_q;
endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_W  = 24,
  parameter int DLY_W  = 24,
  parameter int LEN_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trig_in,
  output logic              win_end,
  output logic [1:0]        fmt_sel,
  output logic              pkt_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             start_req, stop_req, trig_rise;
  acq_cfg_t         cfg;
  logic [WIN_W-1:0] width;
  logic [DLY_W-1:0] delay;
  logic [LEN_W-1:0] len;
  acq_state_e       seq_state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acq_regs #(.DATA_W(DATA_W), .WIN_W(WIN_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .state_i(seq_state), .start_o(start_req), .stop_o(stop_req),
    .cfg_o(cfg), .width_o(width), .delay_o(delay), .len_o(len)
  );

  acq_trig_sync #(.STAGES(SYNC_N)) i_trig (
    .clk(clk), .rst_n(rst_int_n), .async_i(trig_in), .rise_o(trig_rise)
  );

  acq_seq #(.WIN_W(WIN_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) i_seq (
    .clk(clk), .rst_n(rst_int_n),
    .start_i(start_req), .stop_i(stop_req), .trig_rise_i(trig_rise),
    .cfg_i(cfg), .width_i(width), .delay_i(delay), .len_i(len),
    .state_o(seq_state), .win_end_o(win_end), .fmt_o(fmt_sel), .pkt_irq_o(pkt_irq)
  );
endmodule

// File: rtl/acq_window_ctrl_chk.sv
module acq_window_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       win_end,
  input logic       pkt_irq,
  input logic [1:0] fmt_sel,
  input logic       trig_rise
);
  assert_irq_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_irq |-> $past(win_end));

  assert_strobe_in_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> (state == 2'd3));

  assert_fmt_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 2'd3) && ($past(state) == 2'd3)) |-> $stable(fmt_sel));

  assert_delay_from_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 2'd2) && ($past(state) != 2'd2)) |-> ($past(state) == 2'd1));

  assert_armed_exit_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state) == 2'd1) && (state[1] == 1'b1)) |-> $past(trig_rise));

  assert_stop_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state) == 2'd3) && (state == 2'd0)) |-> $past(win_end));
endmodule

bind acq_window_ctrl acq_window_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .state(seq_state), .win_end(win_end),
  .pkt_irq(pkt_irq), .fmt_sel(fmt_sel), .trig_rise(trig_rise)
);

// File: tb/test_acq_window_ctrl.sv
module test_acq_window_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        trig_in = 1'b0;
  logic        win_end;
  logic [1:0]  fmt_sel;
  logic        pkt_irq;

  int n_chk = 0;
  int n_fail = 0;
  int win_seen = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acq_window_ctrl i_acq_window_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .win_end(win_end), .fmt_sel(fmt_sel), .pkt_irq(pkt_irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic status_is(input string req, input int exp);
    logic [31:0] d;
    bus_read(3'd5, d);
    check(req, d, exp);
  endtask

  task automatic clr();
    win_seen = 0; irq_seen = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      if (win_end) win_seen++;
      if (pkt_irq) irq_seen++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 win_end in reset", win_end, 0);
    check("R1 pkt_irq in reset", pkt_irq, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    status_is("R1 status after reset", 0);
    check("R1 win_end after reset", win_end, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(3'd2, 32'd123);
    bus_write(3'd3, 32'd77);
    bus_write(3'd4, 32'd9);
    bus_write(3'd1, 32'd6);
    bus_read(3'd2, d); check("R2 width readback", d, 123);
    bus_read(3'd3, d); check("R2 delay readback", d, 77);
    bus_read(3'd4, d); check("R2 length readback", d, 9);
    bus_read(3'd1, d); check("R2 config readback", d, 6);
    bus_read(3'd0, d); check("R2 control reads zero", d, 0);
  endtask

  // continuous run of k windows of width w in format f
  task automatic t_cont(input int w, input int f, input int k, input int exp_irq);
    bus_write(3'd1, f);
    bus_write(3'd2, w);
    bus_write(3'd0, 32'd1);
    clr();
    run(k * w + 1);
    check($sformatf("R3 windows w=%0d", w), win_seen, k);
    check($sformatf("R5 irqs fmt=%0d", f), irq_seen, exp_irq);
    check("R5 fmt_sel held", fmt_sel, f);
    bus_write(3'd0, 32'd2);
    run(w + 2);
    status_is("R6 idle after stop", 0);
  endtask

  task automatic t_zero_width();
    bus_write(3'd1, 32'd0);
    bus_write(3'd2, 32'd0);
    bus_write(3'd0, 32'd1);
    clr();
    run(10);
    check("R4 one-cycle windows", win_seen, 10);
    bus_write(3'd0, 32'd2);
    run(2);
    status_is("R4 idle after stop", 0);
  endtask

  task automatic t_stop();
    bus_write(3'd1, 32'd0);
    bus_write(3'd2, 32'd20);
    bus_write(3'd0, 32'd1);
    bus_write(3'd0, 32'd2);
    status_is("R6 still acquiring after stop", 3);
    clr();
    run(25);
    check("R6 stop waits for boundary", win_seen, 1);
    status_is("R6 idle at boundary", 0);
    bus_write(3'd1, 32'd4);
    bus_write(3'd0, 32'd1);
    status_is("R7 armed after start", 1);
    bus_write(3'd0, 32'd2);
    status_is("R6 stop from armed", 0);
  endtask

  task automatic t_trig();
    bus_write(3'd1, 32'd4);
    bus_write(3'd2, 32'd4);
    bus_write(3'd3, 32'd6);
    bus_write(3'd4, 32'd3);
    bus_write(3'd0, 32'd1);
    status_is("R7 armed", 1);
    clr();
    trig_in = 1'b1;
    run(4);
    status_is("R7 delay phase", 2);
    trig_in = 1'b0;
    run(4);
    status_is("R7 still delaying", 2);
    run(1);
    status_is("R7 acquire after delay", 3);
    trig_in = 1'b1;
    run(3);
    trig_in = 1'b0;
    run(30);
    check("R8 length windows", win_seen, 3);
    check("R9 retrigger ignored irqs", irq_seen, 3);
    status_is("R8 idle after length", 0);
  endtask

  task automatic t_flush();
    bus_write(3'd1, 32'd6);
    bus_write(3'd2, 32'd3);
    bus_write(3'd3, 32'd0);
    bus_write(3'd4, 32'd5);
    bus_write(3'd0, 32'd1);
    clr();
    trig_in = 1'b1;
    run(3);
    trig_in = 1'b0;
    check("R5 fmt_sel 4x8", fmt_sel, 2);
    status_is("R7 zero delay direct acquire", 3);
    run(30);
    check("R8 windows", win_seen, 5);
    check("R8 partial word flushed", irq_seen, 2);
    status_is("R8 idle", 0);
  endtask

  task automatic t_unlimited();
    bus_write(3'd1, 32'd4);
    bus_write(3'd2, 32'd2);
    bus_write(3'd4, 32'd0);
    bus_write(3'd0, 32'd1);
    trig_in = 1'b1;
    run(3);
    trig_in = 1'b0;
    run(40);
    status_is("R8 zero length keeps running", 3);
    bus_write(3'd0, 32'd2);
    run(4);
    status_is("R8 stopped", 0);
  endtask

  task automatic t_trig_idle();
    clr();
    trig_in = 1'b1;
    run(3);
    trig_in = 1'b0;
    run(5);
    status_is("R9 trigger in idle", 0);
    check("R9 no windows from idle trigger", win_seen, 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_cont(5, 0, 4, 4);
    t_cont(5, 1, 8, 4);
    t_cont(5, 2, 8, 2);
    t_cont(3, 3, 4, 4);
    t_zero_width();
    t_stop();
    t_trig();
    t_flush();
    t_unlimited();
    t_trig_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule